// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands a command to an embedded power-management controller and collects the answer. The host writes optional payload words into a four-word outbound buffer, may set source and destination pointers, and then writes a command word. That write raises a one-cycle command-valid pulse toward the controller, with the opcode, sub-command and clamped payload length decoded, and marks the mailbox busy.

The controller reads the outbound payload through its own word index, fills a four-word inbound buffer through a separate write port, and finishes by pulsing done with an 8-bit result code. Completion clears busy, records the code and an error flag, and, if the command asked for it, raises an interrupt to the host that holds until the host clears it by writing a one to the interrupt bit of the status register.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the status word reads 0, the interrupt output is low and no command-valid pulse is present.
- R2: A host write to byte offset 0x00 while idle makes status bit 0 (busy) read 1 from the next cycle and raises ctl_cmd_valid for exactly that one cycle, with opcode taken from command bits 7:0, sub-command from bits 15:12 and payload length from bits 23:16.
- R3: A payload length above 16 in the command word is presented to the controller as 16; lengths up to 16 pass unchanged.
- R4: A done pulse while busy clears busy on that edge, sets status bit 1 (error) exactly when the result code is non-zero and places the code in status bits 23:16; a done pulse while idle changes nothing.
- R5: Completion sets status bit 2 and irq_o only when bit 8 of the issuing command was 1; the flag then stays high until a host write to offset 0x04 with byte lane 0 enabled and data bit 2 set clears it; other status bits are not writable.
- R6: A command write while busy is ignored: no new valid pulse, decoded fields and the command readback at 0x00 keep their pending values.
- R7: Host writes to the outbound buffer (0x80 to 0x8F, word index from address bits 3:2) follow the byte strobes when idle and are ignored while busy; the controller sees the words through ctl_wbuf_idx.
- R8: The inbound buffer (0x90 to 0x9F) is written only from the controller port; host writes there have no effect and host reads return what the controller loaded.
- R9: The source pointer (0x08) and destination pointer (0x0C) are host read/write with byte strobes and are presented on ctl_sptr and ctl_dptr.
- R10: Accepting a new command clears the previous error flag and result code in status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host byte address, word aligned (bits 1:0 must be zero) |
| host_wr | input | 1 | Host write enable, one access per cycle |
| host_be | input | 4 | Host byte-lane strobes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| irq_o | output | 1 | Completion interrupt, level, cleared by write-one |
| ctl_cmd_valid | output | 1 | One-cycle pulse when a command is accepted |
| ctl_opcode | output | 8 | Decoded opcode of the pending command |
| ctl_subcmd | output | 4 | Decoded sub-command |
| ctl_len | output | 5 | Payload length in bytes, clamped to 16 |
| ctl_sptr | output | 32 | Source pointer register |
| ctl_dptr | output | 32 | Destination pointer register |
| ctl_wbuf_idx | input | 2 | Outbound buffer word index for the controller |
| ctl_wbuf_data | output | 32 | Outbound buffer word at ctl_wbuf_idx |
| ctl_rbuf_we | input | 1 | Inbound buffer write strobe |
| ctl_rbuf_idx | input | 2 | Inbound buffer word index |
| ctl_rbuf_data | input | 32 | Inbound buffer write data |
| ctl_done | input | 1 | Completion pulse from the controller |
| ctl_err_code | input | 8 | Result code sampled with ctl_done |

## Verification
The hardest situations to reach are the ones that only exist while a command is outstanding: a second command word, an outbound-buffer write and an inbound-buffer host write all landing during busy, and a stray done arriving after completion. The bench plays the controller itself, so it holds the mailbox busy for as long as it likes, fires those host writes in that window, loads the inbound buffer, and only then issues done; the scoreboard holds exactly the commands that should be accepted, so any extra valid pulse from the ignored write shows up as an unmatched item.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Host byte offsets (fixed by the software-visible layout)
  localparam int unsigned OFF_CMD  = 'h00;
  localparam int unsigned OFF_STAT = 'h04;
  localparam int unsigned OFF_SPTR = 'h08;
  localparam int unsigned OFF_DPTR = 'h0C;
  localparam int unsigned OFF_WBUF = 'h80;
  localparam int unsigned OFF_RBUF = 'h90;

  // Command word fields
  localparam int CMD_OP_W    = 8;
  localparam int CMD_IRQ_BIT = 8;
  localparam int CMD_SUB_LSB = 12;
  localparam int CMD_SUB_W   = 4;
  localparam int CMD_LEN_LSB = 16;
  localparam int CMD_LEN_W   = 8;

  // Status word fields
  localparam int ST_BUSY     = 0;
  localparam int ST_ERR      = 1;
  localparam int ST_IRQ      = 2;
  localparam int ST_CODE_LSB = 16;

  typedef struct packed {
    logic                 irq_req;
    logic [CMD_SUB_W-1:0] sub;
    logic [CMD_LEN_W-1:0] len;
    logic [CMD_OP_W-1:0]  op;
  } cmd_fields_t;

  function automatic cmd_fields_t cmd_decode(input logic [31:0] w);
    cmd_fields_t f;
    f.op      = w[CMD_OP_W-1:0];
    f.irq_req = w[CMD_IRQ_BIT];
    f.sub     = w[CMD_SUB_LSB +: CMD_SUB_W];
    f.len     = w[CMD_LEN_LSB +: CMD_LEN_W];
    return f;
  endfunction

endpackage

// File: rtl/mbx_word_buf.sv
module mbx_word_buf #(
  parameter int WORDS    = 4,
  parameter int DW       = 32,
  parameter int RD_PORTS = 2,
  localparam int IDX_W   = $clog2(WORDS),
  localparam int BE_W    = DW / 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [BE_W-1:0]           wr_be,
  input  logic [DW-1:0]             wr_data,
  input  logic [RD_PORTS*IDX_W-1:0] rd_idx,
  output logic [RD_PORTS*DW-1:0]    rd_data
);

  logic [WORDS*DW-1:0] flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q;
    logic [DW-1:0] word_d;
    logic          word_en;

    assign word_en = wr_en && (wr_idx == IDX_W'(w));

    always_comb begin
      word_d = word_q;
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) word_d[b*8 +: 8] = wr_data[b*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign flat[w*DW +: DW] = word_q;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_data[p*DW +: DW] = flat[rd_idx[p*IDX_W +: IDX_W]*DW +: DW];
  end

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int MAX_LEN = 16,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic [31:0]          cmd_wdata,
  input  logic                 irq_clr,
  input  logic                 done,
  input  logic [CODE_W-1:0]    done_code,
  output logic                 busy,
  output logic                 err,
  output logic [CODE_W-1:0]    code,
  output logic                 irq_pend,
  output logic [31:0]          cmd_word,
  output logic                 cmd_valid,
  output logic [CMD_OP_W-1:0]  op,
  output logic [CMD_SUB_W-1:0] sub,
  output logic [LEN_W-1:0]     len
);

  logic              busy_q, busy_d;
  logic              err_q, err_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              irq_q, irq_d;
  logic              vld_q, vld_d;
  logic [31:0]       cmd_q;
  logic              accept, finish;
  cmd_fields_t       cur;

  assign cur    = cmd_decode(cmd_q);
  assign accept = cmd_wr && !busy_q;
  assign finish = done && busy_q;

  // next state
  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    code_d = code_q;
    irq_d  = irq_q;
    vld_d  = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      vld_d  = 1'b1;
      err_d  = 1'b0;
      code_d = '0;
    end
    if (irq_clr) irq_d = 1'b0;
    if (finish) begin
      busy_d = 1'b0;
      err_d  = (done_code != '0);
      code_d = done_code;
      if (cur.irq_req) irq_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      irq_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      code_q <= code_d;
      irq_q  <= irq_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= cmd_wdata;
  end

  assign busy      = busy_q;
  assign err       = err_q;
  assign code      = code_q;
  assign irq_pend  = irq_q;
  assign cmd_word  = cmd_q;
  assign cmd_valid = vld_q;
  assign op        = cur.op;
  assign sub       = cur.sub;
  assign len       = (cur.len > CMD_LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cur.len[LEN_W-1:0];

endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              busy,
  input  logic [31:0]       status_word,
  input  logic [31:0]       cmd_word,
  input  logic [31:0]       wbuf_rdata,
  input  logic [31:0]       rbuf_rdata,
  output logic              cmd_wr,
  output logic              irq_clr,
  output logic              wbuf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [31:0]       sptr,
  output logic [31:0]       dptr
);

  logic [WA_W-1:0] wa;
  logic            aligned;
  logic            hit_cmd, hit_stat, hit_sptr, hit_dptr, hit_wbuf, hit_rbuf;
  logic [31:0]     sptr_q, sptr_d, dptr_q, dptr_d;
  logic            sptr_en, dptr_en;

  assign wa      = host_addr[ADDR_W-1:2];
  assign aligned = (host_addr[1:0] == 2'b00);
  assign buf_idx = wa[IDX_W-1:0];

  assign hit_cmd  = aligned && (wa == WA_W'(OFF_CMD  / 4));
  assign hit_stat = aligned && (wa == WA_W'(OFF_STAT / 4));
  assign hit_sptr = aligned && (wa == WA_W'(OFF_SPTR / 4));
  assign hit_dptr = aligned && (wa == WA_W'(OFF_DPTR / 4));
  assign hit_wbuf = aligned && ((wa >> IDX_W) == WA_W'((OFF_WBUF / 4) >> IDX_W));
  assign hit_rbuf = aligned && ((wa >> IDX_W) == WA_W'((OFF_RBUF / 4) >> IDX_W));

  assign cmd_wr  = host_wr && hit_cmd;
  assign irq_clr = host_wr && hit_stat && host_be[0] && host_wdata[ST_IRQ];
  assign wbuf_we = host_wr && hit_wbuf && !busy;
  assign sptr_en = host_wr && hit_sptr;
  assign dptr_en = host_wr && hit_dptr;

  // pointer next state, byte-lane merge
  always_comb begin
    sptr_d = sptr_q;
    dptr_d = dptr_q;
    for (int b = 0; b < 4; b++) begin
      if (host_be[b]) begin
        sptr_d[b*8 +: 8] = host_wdata[b*8 +: 8];
        dptr_d[b*8 +: 8] = host_wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sptr_q <= '0;
    else if (sptr_en) sptr_q <= sptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dptr_q <= '0;
    else if (dptr_en) dptr_q <= dptr_d;
  end

  assign sptr = sptr_q;
  assign dptr = dptr_q;

  // read mux
  always_comb begin
    host_rdata = '0;
    if (hit_cmd)       host_rdata = cmd_word;
    else if (hit_stat) host_rdata = status_word;
    else if (hit_sptr) host_rdata = sptr_q;
    else if (hit_dptr) host_rdata = dptr_q;
    else if (hit_wbuf) host_rdata = wbuf_rdata;
    else if (hit_rbuf) host_rdata = rbuf_rdata;
  end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_BYTES = 16,
  parameter int CODE_W    = 8,
  localparam int BUF_WORDS = BUF_BYTES / 4,
  localparam int IDX_W     = $clog2(BUF_WORDS),
  localparam int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 host_wr,
  input  logic [3:0]           host_be,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  output logic                 irq_o,
  output logic                 ctl_cmd_valid,
  output logic [CMD_OP_W-1:0]  ctl_opcode,
  output logic [CMD_SUB_W-1:0] ctl_subcmd,
  output logic [LEN_W-1:0]     ctl_len,
  output logic [31:0]          ctl_sptr,
  output logic [31:0]          ctl_dptr,
  input  logic [IDX_W-1:0]     ctl_wbuf_idx,
  output logic [31:0]          ctl_wbuf_data,
  input  logic                 ctl_rbuf_we,
  input  logic [IDX_W-1:0]     ctl_rbuf_idx,
  input  logic [31:0]          ctl_rbuf_data,
  input  logic                 ctl_done,
  input  logic [CODE_W-1:0]    ctl_err_code
);

  logic              cmd_wr, irq_clr, wbuf_we;
  logic              busy, err, irq_pend;
  logic [CODE_W-1:0] code;
  logic [31:0]       cmd_word, status_word;
  logic [IDX_W-1:0]  buf_idx;
  logic [2*32-1:0]   wbuf_rd;
  logic [31:0]       rbuf_rd;

  always_comb begin
    status_word = '0;
    status_word[ST_BUSY] = busy;
    status_word[ST_ERR]  = err;
    status_word[ST_IRQ]  = irq_pend;
    status_word[ST_CODE_LSB +: CODE_W] = code;
  end

  mbx_host_if #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_host (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_be(host_be),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .status_word(status_word), .cmd_word(cmd_word),
    .wbuf_rdata(wbuf_rd[31:0]), .rbuf_rdata(rbuf_rd),
    .cmd_wr(cmd_wr), .irq_clr(irq_clr), .wbuf_we(wbuf_we),
    .buf_idx(buf_idx), .sptr(ctl_sptr), .dptr(ctl_dptr)
  );

  mbx_seq #(.CODE_W(CODE_W), .MAX_LEN(BUF_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(host_wdata), .irq_clr(irq_clr),
    .done(ctl_done), .done_code(ctl_err_code),
    .busy(busy), .err(err), .code(code), .irq_pend(irq_pend),
    .cmd_word(cmd_word), .cmd_valid(ctl_cmd_valid),
    .op(ctl_opcode), .sub(ctl_subcmd), .len(ctl_len)
  );

  // outbound: host writes, host and controller read
  mbx_word_buf #(.WORDS(BUF_WORDS), .DW(32), .RD_PORTS(2)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wbuf_we), .wr_idx(buf_idx), .wr_be(host_be), .wr_data(host_wdata),
    .rd_idx({ctl_wbuf_idx, buf_idx}), .rd_data(wbuf_rd)
  );

  // inbound: controller writes whole words, host reads
  mbx_word_buf #(.WORDS(BUF_WORDS), .DW(32), .RD_PORTS(1)) u_rbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ctl_rbuf_we), .wr_idx(ctl_rbuf_idx), .wr_be(4'hF), .wr_data(ctl_rbuf_data),
    .rd_idx(buf_idx), .rd_data(rbuf_rd)
  );

  assign ctl_wbuf_data = wbuf_rd[63:32];
  assign irq_o         = irq_pend;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic             busy,
  input logic             done,
  input logic             vld,
  input logic [LEN_W-1:0] len,
  input logic [7:0]       op,
  input logic             irq,
  input logic             irq_clr,
  input logic             irq_req
);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy |=> busy && vld);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> len <= LEN_W'(MAX_LEN));

  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |=> !busy);

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done && !irq_req && !irq |=> !irq);

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr && !done |=> busy && !vld && $stable(op));

endmodule

bind cmd_mailbox mbx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(busy), .done(ctl_done),
  .vld(ctl_cmd_valid), .len(ctl_len), .op(ctl_opcode), .irq(irq_o),
  .irq_clr(irq_clr), .irq_req(cmd_word[8])
);

// File: tb/tb_cmd_mailbox.sv
`timescale 1ns/100ps
module tb_cmd_mailbox;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq_o;
  logic        ctl_cmd_valid;
  logic [7:0]  ctl_opcode;
  logic [3:0]  ctl_subcmd;
  logic [4:0]  ctl_len;
  logic [31:0] ctl_sptr, ctl_dptr;
  logic [1:0]  ctl_wbuf_idx = '0;
  logic [31:0] ctl_wbuf_data;
  logic        ctl_rbuf_we = 1'b0;
  logic [1:0]  ctl_rbuf_idx = '0;
  logic [31:0] ctl_rbuf_data = '0;
  logic        ctl_done = 1'b0;
  logic [7:0]  ctl_err_code = '0;

  always #2.5 clk = ~clk;

  cmd_mailbox dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_o(irq_o), .ctl_cmd_valid(ctl_cmd_valid), .ctl_opcode(ctl_opcode),
    .ctl_subcmd(ctl_subcmd), .ctl_len(ctl_len), .ctl_sptr(ctl_sptr),
    .ctl_dptr(ctl_dptr), .ctl_wbuf_idx(ctl_wbuf_idx), .ctl_wbuf_data(ctl_wbuf_data),
    .ctl_rbuf_we(ctl_rbuf_we), .ctl_rbuf_idx(ctl_rbuf_idx), .ctl_rbuf_data(ctl_rbuf_data),
    .ctl_done(ctl_done), .ctl_err_code(ctl_err_code)
  );

  typedef struct packed { logic [7:0] op; logic [3:0] sub; logic [4:0] len; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rd;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every accepted command must match the queue head
  always @(negedge clk) begin
    if (rst_n && ctl_cmd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R6: actual unexpected command %h expected none", ctl_opcode);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R2 decoded fields", {15'b0, ctl_opcode, ctl_subcmd, ctl_len},
              {15'b0, e.op, e.sub, e.len});
      end
    end
  end

  task automatic host_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_be = be; host_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0; host_be = '0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  // driver: expected fields follow R2/R3 (length clamp to 16)
  task automatic issue_cmd(input logic [31:0] w, input bit expect_accept);
    exp_t e;
    e.op  = w[7:0];
    e.sub = w[15:12];
    e.len = (w[23:16] > 8'd16) ? 5'd16 : w[20:16];
    if (expect_accept) exp_q.push_back(e);
    host_write(8'h00, w, 4'hF);
  endtask

  task automatic fw_done(input logic [7:0] c);
    @(negedge clk);
    ctl_done = 1'b1; ctl_err_code = c;
    @(posedge clk);
    @(negedge clk);
    ctl_done = 1'b0;
  endtask

  task automatic fw_load(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk);
    ctl_rbuf_we = 1'b1; ctl_rbuf_idx = i; ctl_rbuf_data = d;
    @(posedge clk);
    @(negedge clk);
    ctl_rbuf_we = 1'b0;
  endtask

  bit finished = 0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    host_read(8'h04, rd);  check("R1 status", rd, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 valid", {31'b0, ctl_cmd_valid}, 32'h0);

    // R7 outbound buffer with byte strobes while idle
    host_write(8'h80, 32'h11223344, 4'hF);
    host_write(8'h84, 32'hAABBCCDD, 4'b0101);
    ctl_wbuf_idx = 2'd0; #1; check("R7 ctl word0", ctl_wbuf_data, 32'h11223344);
    ctl_wbuf_idx = 2'd1; #1; check("R7 ctl word1 strobes", ctl_wbuf_data, 32'h00BB00DD);
    host_read(8'h84, rd); check("R7 host readback", rd, 32'h00BB00DD);

    // R9 pointers
    host_write(8'h08, 32'hDEADBEEF, 4'hF);
    host_write(8'h0C, 32'h12345678, 4'b0011);
    check("R9 sptr port", ctl_sptr, 32'hDEADBEEF);
    check("R9 dptr port", ctl_dptr, 32'h00005678);
    host_read(8'h0C, rd); check("R9 dptr read", rd, 32'h00005678);

    // R2 command accepted, interrupt requested
    issue_cmd(32'h000831A5, 1'b1);
    check("R2 valid pulse", {31'b0, ctl_cmd_valid}, 32'h1);
    host_read(8'h04, rd); check("R2 busy", rd, 32'h1);
    @(negedge clk);
    check("R2 pulse one cycle", {31'b0, ctl_cmd_valid}, 32'h0);

    // R6 command while busy ignored
    issue_cmd(32'h00000077, 1'b0);
    check("R6 opcode kept", {24'b0, ctl_opcode}, 32'hA5);
    host_read(8'h00, rd); check("R6 cmd readback", rd, 32'h000831A5);

    // R7 outbound write while busy ignored
    host_write(8'h80, 32'hFFFFFFFF, 4'hF);
    ctl_wbuf_idx = 2'd0; #1; check("R7 busy write ignored", ctl_wbuf_data, 32'h11223344);

    // R8 inbound buffer from controller only
    fw_load(2'd0, 32'hCAFEF00D);
    fw_load(2'd3, 32'h0BADC0DE);
    host_write(8'h90, 32'h00000000, 4'hF);
    host_read(8'h90, rd); check("R8 host write ignored", rd, 32'hCAFEF00D);
    host_read(8'h9C, rd); check("R8 word3", rd, 32'h0BADC0DE);

    // R4 / R5 completion with interrupt
    fw_done(8'h00);
    host_read(8'h04, rd); check("R4 done ok status", rd, 32'h00000004);
    check("R5 irq raised", {31'b0, irq_o}, 32'h1);
    host_write(8'h04, 32'h00000003, 4'hF);
    host_read(8'h04, rd); check("R5 other bits not writable", rd, 32'h00000004);
    host_write(8'h04, 32'h00000004, 4'hF);
    host_read(8'h04, rd); check("R5 w1c", rd, 32'h0);
    check("R5 irq cleared", {31'b0, irq_o}, 32'h0);

    // R3 clamp, no interrupt requested, error code
    issue_cmd(32'h001F203C, 1'b1);
    @(negedge clk);
    issue_cmd(32'h0010203D, 1'b0);
    fw_done(8'h05);
    host_read(8'h04, rd); check("R4 error code", rd, 32'h00050002);
    check("R5 no irq without request", {31'b0, irq_o}, 32'h0);
    fw_done(8'h07);
    host_read(8'h04, rd); check("R4 done while idle ignored", rd, 32'h00050002);

    // R3 exact boundary 16 passes unchanged
    issue_cmd(32'h00100042, 1'b1);
    check("R3 len 16", {27'b0, ctl_len}, 32'd16);
    fw_done(8'h00);

    // R10 new command clears previous error
    fw_done(8'h00);
    issue_cmd(32'h00000101, 1'b1);
    fw_done(8'h06);
    host_read(8'h04, rd); check("R10 prior cleared, new error", rd, 32'h00060006);
    issue_cmd(32'h00000100, 1'b1);
    host_read(8'h04, rd); check("R10 err and code cleared", rd, 32'h00000005);
    fw_done(8'h00);
    host_read(8'h04, rd); check("R5 irq still pending", rd, 32'h00000004);
    host_write(8'h04, 32'h00000004, 4'b0010);
    check("R5 lane0 needed", {31'b0, irq_o}, 32'h1);
    host_write(8'h04, 32'h00000004, 4'b0001);
    host_read(8'h04, rd); check("R5 cleared", rd, 32'h0);

    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 32'd0);
    finished = 1;
    summary();
  end

endmodule